// File: doc/BRIEF.md
# Source-Selectable Prescaled Interval Timer

This block is an interval timer that advances an up-counter at a rate chosen by one 3-bit clock-select code. The code selects one of two kinds of source. Four of its values divide the bus clock by a power of four. Two others count edges of slow tick signals: a 32.768 kHz real-time tick and an external reference tick. Those tick signals arrive as plain levels from another clock domain. Each one passes through a two-flop synchroniser and then a rising-edge detector, so every low-to-high transition produces exactly one count.

When the counter equals the compare value at a count event, it returns to zero instead of incrementing, and a sticky interrupt flag is set. Software reaches the control, compare, counter and status registers through a plain single-cycle register port. Writes take effect on the clock edge where `reg_wr_i` is high. Reads are combinational from `reg_addr_i`. The port has no handshake, so it never applies back-pressure and every access completes in the cycle it is presented. The interrupt output follows the sticky flag.

Top module: `ptmr_top`

## Requirements
- R1: After reset, control reads 0 (run bit 0 = 0, select field bits 3:1 = 0), compare (address 1) reads all ones in its low CNT_W bits, counter (address 2) reads 0, status (address 3) reads 0, and `irq_o` is 0.
- R2: With run = 1 and select codes 0, 1, 2 and 3, the counter advances once per 4, 16, 64 and 256 bus clocks respectively. Starting from a stopped timer, the first count lands on the edge that ends the last clock of the first full period.
- R3: With select code 4, the counter advances once per rising edge of `rtc_lvl_i`. A level held high counts only once.
- R4: With select code 5, the counter advances once per rising edge of `ext_lvl_i`. While code 4 is selected, edges on `ext_lvl_i` leave the counter unchanged.
- R5: Select codes 6 and 7 are reserved and hold the counter still, whatever the clock and tick inputs do.
- R6: With run = 0 the counter holds its value, and the prescaler phase restarts from zero.
- R7: On a count event where counter equals compare, the counter becomes 0 and the status flag (status bit 0) is set. On any other count event the counter increments by one.
- R8: The status flag stays set until software writes 1 to status bit 0. Writing 0 there leaves it set. A set on the same edge wins over a clear.
- R9: A control write that changes the select code restarts the prescaler phase, so the first count under the new divided code comes one full new period after the write.
- R10: A write to the counter address loads the counter directly, taking priority over a count event on the same edge.
- R11: `irq_o` is high exactly when the status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_lvl_i | input | 1 | Real-time tick level, asynchronous |
| ext_lvl_i | input | 1 | External reference tick level, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 compare, 2 counter, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt, mirrors the sticky flag |

## Verification
The assertions assume that register writes reach the counter only through address 2. They also assume that each slow tick level stays high and stays low for at least three bus clocks, which is what lets the edge detector produce a single isolated pulse per transition. The stimulus meets this by holding every tick level for four clocks in each state. Divided-rate runs are always framed by two control writes at a known number of edges apart, so the expected count is the number of edges divided by the period, rounded down.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [2:0] {
    SEL_D4   = 3'd0,
    SEL_D16  = 3'd1,
    SEL_D64  = 3'd2,
    SEL_D256 = 3'd3,
    SEL_RTC  = 3'd4,
    SEL_EXT  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } sel_e;

  localparam int NUM_DIV_CODES = 4;
  localparam int PHASE_W       = 2 * NUM_DIV_CODES;
  localparam int NUM_SRC       = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic logic is_div_code(input sel_e s);
    return (s == SEL_D4) || (s == SEL_D16) || (s == SEL_D64) || (s == SEL_D256);
  endfunction

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= lvl_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  sel_e sel_i,
  input  logic restart_i,
  input  logic rtc_rise_i,
  input  logic ext_rise_i,
  output logic tick_o
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] terminal;
  logic          div_sel;
  logic          div_tick;

  always_comb begin
    div_sel  = is_div_code(sel_i);
    terminal = '0;
    if (div_sel) begin
      terminal = PW'((32'd1 << (2 * (32'(sel_i[1:0]) + 1))) - 32'd1);
    end
    div_tick = run_i && div_sel && (phase_q == terminal);
  end

  always_comb begin
    unique case (sel_i)
      SEL_D4, SEL_D16, SEL_D64, SEL_D256: tick_o = div_tick;
      SEL_RTC:                            tick_o = run_i && rtc_rise_i;
      SEL_EXT:                            tick_o = run_i && ext_rise_i;
      default:                            tick_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run_i || restart_i || !div_sel || div_tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic match_evt;

  assign match_evt = tick_i && !load_i && (cnt_o == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
    end else if (tick_i) begin
      cnt_o <= match_evt ? '0 : cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (match_evt) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_lvl_i,
  input  logic              ext_lvl_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             run_q;
  sel_e             sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             tick;
  logic             restart;
  logic             ctrl_wr, cmp_wr, cnt_wr, stat_clr;
  sel_e             new_sel;
  logic [NUM_SRC-1:0] lvl_vec, rise_vec;

  assign ctrl_wr  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign cmp_wr   = reg_wr_i && (reg_addr_i == ADDR_CMP);
  assign cnt_wr   = reg_wr_i && (reg_addr_i == ADDR_CNT);
  assign stat_clr = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];
  assign new_sel  = sel_e'(reg_wdata_i[3:1]);
  assign restart  = ctrl_wr && (new_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= SEL_D4;
      cmp_q <= '1;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata_i[0];
        sel_q <= new_sel;
      end
      if (cmp_wr) begin
        cmp_q <= reg_wdata_i[CNT_W-1:0];
      end
    end
  end

  assign lvl_vec = {ext_lvl_i, rtc_lvl_i};

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    ptmr_sync_edge u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl_vec[gi]),
      .rise_o(rise_vec[gi])
    );
  end

  ptmr_prescale #(.PW(PHASE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .sel_i     (sel_q),
    .restart_i (restart),
    .rtc_rise_i(rise_vec[0]),
    .ext_rise_i(rise_vec[1]),
    .tick_o    (tick)
  );

  ptmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .load_i    (cnt_wr),
    .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .cmp_i     (cmp_q),
    .clr_i     (stat_clr),
    .cnt_o     (cnt),
    .flag_o    (flag)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {{(DATA_W-4){1'b0}}, sel_q, run_q};
      ADDR_CMP:  reg_rdata_o = {{PAD_W{1'b0}}, cmp_q};
      ADDR_CNT:  reg_rdata_o = {{PAD_W{1'b0}}, cnt};
      default:   reg_rdata_o = {{(DATA_W-1){1'b0}}, flag};
    endcase
  end

  assign irq_o = flag;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              run,
  input logic [2:0]        sel,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              flag
);
  logic cnt_wr, clr_wr;
  assign cnt_wr = reg_wr_i && (reg_addr_i == 2'd2);
  assign clr_wr = reg_wr_i && (reg_addr_i == 2'd3) && reg_wdata_i[0];

  AST_RESERVED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 3'd6) |-> !tick); // R5

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R6

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R6

  AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == cmp) |=> (cnt == '0) && flag); // R7

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt != cmp) |=> (cnt == $past(cnt) + 1'b1)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(reg_wdata_i[CNT_W-1:0]))); // R10

  AST_RTC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == 3'd4) |=> !(tick && sel == 3'd4)); // R3
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .run        (run_q),
  .sel        (sel_q),
  .tick       (tick),
  .cnt        (cnt),
  .cmp        (cmp_q),
  .flag       (flag)
);

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_lvl_i = 1'b0;
  logic        ext_lvl_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_lvl_i(rtc_lvl_i), .ext_lvl_i(ext_lvl_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : reg_rdata_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk);
    #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    sb_q.push_back('{1'b0, e, tag});
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    sb_q.push_back('{1'b1, {31'd0, e}, tag});
  endtask

  function automatic logic [31:0] ctl(input int sel, input bit run);
    return {28'd0, 3'(sel), run};
  endfunction

  // start at edge E0, stop at edge E(m); counter sees m edges of running
  task automatic run_window(input int sel, input int m);
    wr(2'd0, ctl(sel, 1'b1));
    repeat (m - 1) @(posedge clk);
    wr(2'd0, ctl(sel, 1'b0));
  endtask

  task automatic pulse(input bit use_ext);
    @(negedge clk);
    if (use_ext) ext_lvl_i = 1'b1; else rtc_lvl_i = 1'b1;
    repeat (4) @(negedge clk);
    if (use_ext) ext_lvl_i = 1'b0; else rtc_lvl_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 32'd0, "R1 ctrl");
    rd(2'd1, 32'h0000_FFFF, "R1 cmp");
    rd(2'd2, 32'd0, "R1 cnt");
    rd(2'd3, 32'd0, "R1 stat");
    chk_irq(1'b0, "R1 irq");

    // R10 direct counter load
    wr(2'd2, 32'h0000_1234);
    rd(2'd2, 32'h0000_1234, "R10 load");

    // R2 divided rates
    wr(2'd2, 0); run_window(0, 23);  rd(2'd2, 32'd5, "R2 div4");
    rd(2'd0, ctl(0, 1'b0), "R2 ctrl readback");
    wr(2'd2, 0); run_window(1, 50);  rd(2'd2, 32'd3, "R2 div16");
    wr(2'd2, 0); run_window(2, 130); rd(2'd2, 32'd2, "R2 div64");
    wr(2'd2, 0); run_window(3, 600); rd(2'd2, 32'd2, "R2 div256");

    // R6 stopped timer holds
    wr(2'd0, ctl(0, 1'b0));
    repeat (50) @(posedge clk);
    rd(2'd2, 32'd2, "R6 hold when stopped");

    // R9 select change restarts the phase
    wr(2'd2, 0);
    wr(2'd0, ctl(1, 1'b1));
    repeat (9) @(posedge clk);
    wr(2'd0, ctl(0, 1'b1));
    repeat (6) @(posedge clk);
    wr(2'd0, ctl(0, 1'b0));
    rd(2'd2, 32'd1, "R9 phase restart");

    // R3 real-time ticks
    wr(2'd2, 0);
    wr(2'd0, ctl(4, 1'b1));
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    rd(2'd2, 32'd3, "R3 rtc edges");
    @(negedge clk) rtc_lvl_i = 1'b1;
    repeat (20) @(negedge clk);
    rd(2'd2, 32'd4, "R3 held level counts once");
    rtc_lvl_i = 1'b0;
    repeat (4) @(negedge clk);

    // R4 external source, ignored under code 4
    pulse(1'b1); pulse(1'b1);
    rd(2'd2, 32'd4, "R4 ext ignored under rtc code");
    wr(2'd0, ctl(5, 1'b1));
    pulse(1'b1); pulse(1'b1);
    pulse(1'b0);
    rd(2'd2, 32'd6, "R4 ext edges");

    // R5 reserved codes
    wr(2'd0, ctl(6, 1'b1));
    pulse(1'b0); pulse(1'b1);
    repeat (300) @(posedge clk);
    rd(2'd2, 32'd6, "R5 code6 holds");
    wr(2'd0, ctl(7, 1'b1));
    pulse(1'b0); pulse(1'b1);
    repeat (300) @(posedge clk);
    rd(2'd2, 32'd6, "R5 code7 holds");

    // R7 compare match
    wr(2'd0, ctl(0, 1'b0));
    wr(2'd1, 32'd2);
    wr(2'd2, 0);
    run_window(0, 11);
    rd(2'd2, 32'd2, "R7 before match");
    rd(2'd3, 32'd0, "R7 flag before match");
    run_window(0, 4);
    rd(2'd2, 32'd0, "R7 wrap to zero");
    rd(2'd3, 32'd1, "R7 flag set");
    chk_irq(1'b1, "R11 irq high with flag");

    // R8 sticky flag
    wr(2'd3, 32'd0);
    rd(2'd3, 32'd1, "R8 write 0 keeps flag");
    wr(2'd3, 32'd1);
    rd(2'd3, 32'd0, "R8 write 1 clears flag");
    chk_irq(1'b0, "R11 irq low after clear");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule